// File: doc/BRIEF.md
# Three-Lane Bit Realignment Buffer

This block takes three bit-serial lanes, such as the red, green and blue pairs of a serial video link, and re-times them onto one shared read cadence. Each lane has its own small circular bit store and write pointer. Upstream clock recovery marks each lane's recovered bits with a per-lane write strobe in the core clock domain. All three read pointers step together on a common read enable, so every output lane changes on the same clock edge.

When a discontinuity is signalled, every lane is re-centred. A discontinuity is a mode change, a new input selection, or an internal overflow or underflow. On re-centring, each lane's read pointer is placed behind its write pointer by half the store depth. A pseudo-random 0, 1 or 2 extra positions is added to that gap. This leaves a small inter-lane offset that stays fixed until the next discontinuity.

The output is marked valid only under two conditions. The lock flag must be high, and every lane must have drained the stale entries that were left ahead of its fresh data.

Top module: `lane_skew_fifo`

## Requirements
- R1: While reset is asserted, and right after it, out_valid is 0, err_sticky is 0 and all out_bit lanes are 0.
- R2: All out_bit lanes update only on clock edges where rd_en is sampled high. When rd_en is low, every lane holds its previous value.
- R3: A disc pulse sampled on an edge forces out_valid to 0 after that edge. With lock high and rd_en high on every edge, out_valid returns to 1 on the 7th rising edge after the sampling edge (DEPTH/2 + 2 + 1 reads).
- R4: out_valid is 1 after an edge only if lock was sampled high on that edge. Raising lock once the lanes have settled sets out_valid on the edge that samples it.
- R5: After each re-centring, lane k delivers the bit it was given exactly DEPTH/2 + e_k edges later, where e_k is in {0,1,2}. The output inter-lane skew therefore never exceeds the input skew plus 2 bit periods.
- R6: While no discontinuity occurs, each lane's latency stays constant. Every valid output bit equals the input bit written that many edges earlier, in order.
- R7: A read on an empty lane (underflow) sets err_sticky and clears out_valid on the same edge. It re-centres all lanes on the next edge, and out_valid returns 7 edges after that re-centring edge.
- R8: A write to a full lane (DEPTH bits held) with rd_en low (overflow) sets err_sticky and clears out_valid on the same edge. It re-centres all lanes on the next edge, and out_valid returns 7 edges after that re-centring edge.
- R9: Once set, err_sticky stays 1 through later discontinuities until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Common core and read clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_stb | input | LANES | Per-lane strobe: a recovered bit is present |
| wr_bit | input | LANES | Per-lane recovered data bit |
| rd_en | input | 1 | Shared read step for all lanes |
| lock | input | 1 | Upstream recovery is locked |
| disc | input | 1 | Discontinuity pulse, re-centres all lanes |
| out_bit | output | LANES | Realigned lane bits |
| out_valid | output | 1 | Output bits carry fresh, locked data |
| err_sticky | output | 1 | Overflow or underflow seen since reset |

## Verification
Each lane carries one random 10-bit symbol stream serialized LSB first, delayed per lane by a known input skew. The skew sets used are all-equal, one lane late, a spread of three, and two lanes late together. Zero skew isolates the block's own added offset. The spread sets show that the added offset stacks on top of existing skew by at most two bits and never reorders bits. Each lane's latency is measured from the data itself and then held against a scoreboard for many cycles, which separates a fixed offset from one that drifts. Starving one lane and stalling reads tell underflow from overflow, and toggling lock shows that validity depends on lock rather than on fill level alone.

// File: rtl/lsf_pkg.sv
package lsf_pkg;
    localparam int LFSR_W    = 16;
    localparam int CODE_W    = 4;
    localparam int MAX_EXTRA = 2;

    // Map a random nibble to an extra lead: 6 codes give 0, 9 give 1, 1 gives 2.
    function automatic logic [1:0] extra_of(input logic [CODE_W-1:0] code);
        if (code == 4'd15)     return 2'd2;
        else if (code >= 4'd6) return 2'd1;
        else                   return 2'd0;
    endfunction
endpackage

// File: rtl/lsf_lfsr.sv
module lsf_lfsr
    import lsf_pkg::*;
#(
    parameter int OUT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [OUT_W-1:0] rnd
);
    typedef struct packed {
        logic [LFSR_W-1:0] sr;
    } rng_t;

    rng_t r_q, r_d;

    always_comb begin
        r_d    = r_q;
        r_d.sr = {r_q.sr[LFSR_W-2:0],
                  r_q.sr[15] ^ r_q.sr[13] ^ r_q.sr[12] ^ r_q.sr[10]};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q.sr <= 16'hACE1;
        else        r_q    <= r_d;
    end

    assign rnd = r_q.sr[OUT_W-1:0];
endmodule

// File: rtl/lsf_lane.sv
module lsf_lane #(
    parameter int DEPTH = 8,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        init,
    input  logic [AW:0] lead,
    input  logic        wr_en,
    input  logic        wr_bit,
    input  logic        rd_en,
    output logic        dout,
    output logic        ovf,
    output logic        unf
);
    typedef struct packed {
        logic [DEPTH-1:0] mem;
        logic [AW-1:0]    wp;
        logic [AW-1:0]    rp;
        logic [AW:0]      occ;
        logic             dout;
    } lane_t;

    lane_t s_q, s_d;

    always_comb begin
        logic rd_ok;
        logic wr_ok;
        s_d   = s_q;
        ovf   = 1'b0;
        unf   = 1'b0;
        rd_ok = 1'b0;
        wr_ok = 1'b0;
        if (init) begin
            // Re-centre: stale entries between rp and wp are read out first.
            s_d.rp  = s_q.wp - lead[AW-1:0];
            s_d.occ = lead;
        end else begin
            unf   = rd_en && (s_q.occ == '0);
            ovf   = wr_en && (s_q.occ == (AW+1)'(DEPTH)) && !rd_en;
            rd_ok = rd_en && !unf;
            wr_ok = wr_en && !ovf;
            if (wr_ok) begin
                s_d.mem[s_q.wp] = wr_bit;
                s_d.wp          = s_q.wp + AW'(1);
            end
            if (rd_ok) begin
                s_d.dout = s_q.mem[s_q.rp];
                s_d.rp   = s_q.rp + AW'(1);
            end
            s_d.occ = s_q.occ + (AW+1)'(wr_ok) - (AW+1)'(rd_ok);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign dout = s_q.dout;
endmodule

// File: rtl/lane_skew_fifo.sv
module lane_skew_fifo
    import lsf_pkg::*;
#(
    parameter int LANES = 3,
    parameter int DEPTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LANES-1:0] wr_stb,
    input  logic [LANES-1:0] wr_bit,
    input  logic             rd_en,
    input  logic             lock,
    input  logic             disc,
    output logic [LANES-1:0] out_bit,
    output logic             out_valid,
    output logic             err_sticky
);
    localparam int AW       = $clog2(DEPTH);
    localparam int HALF     = DEPTH / 2;
    localparam int LEAD_MAX = HALF + MAX_EXTRA;
    localparam int SW       = $clog2(LEAD_MAX + 2);
    localparam int RND_W    = CODE_W * LANES;

    typedef struct packed {
        logic          init_pend;
        logic          err;
        logic [SW-1:0] settle;
        logic          valid;
    } ctl_t;

    ctl_t c_q, c_d;

    logic [RND_W-1:0] rnd;
    logic [LANES-1:0] ovf_w;
    logic [LANES-1:0] unf_w;
    logic [AW:0]      lead_w [LANES];
    logic             init_w;
    logic             fault_w;

    lsf_lfsr #(.OUT_W(RND_W)) u_rng (
        .clk   (clk),
        .rst_n (rst_n),
        .rnd   (rnd)
    );

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        assign lead_w[k] = (AW+1)'(HALF) + (AW+1)'(extra_of(rnd[k*CODE_W +: CODE_W]));

        lsf_lane #(.DEPTH(DEPTH)) u_lane (
            .clk    (clk),
            .rst_n  (rst_n),
            .init   (init_w),
            .lead   (lead_w[k]),
            .wr_en  (wr_stb[k]),
            .wr_bit (wr_bit[k]),
            .rd_en  (rd_en),
            .dout   (out_bit[k]),
            .ovf    (ovf_w[k]),
            .unf    (unf_w[k])
        );
    end

    assign init_w  = c_q.init_pend | disc;
    assign fault_w = (|ovf_w) | (|unf_w);

    always_comb begin
        c_d           = c_q;
        c_d.init_pend = fault_w;
        c_d.err       = c_q.err | fault_w;
        if (init_w)
            c_d.settle = '0;
        else if (rd_en && (c_q.settle <= SW'(LEAD_MAX)))
            c_d.settle = c_q.settle + SW'(1);
        c_d.valid = lock && !init_w && !fault_w && (c_d.settle > SW'(LEAD_MAX));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q.init_pend <= 1'b1;
            c_q.err       <= 1'b0;
            c_q.settle    <= '0;
            c_q.valid     <= 1'b0;
        end else begin
            c_q <= c_d;
        end
    end

    assign out_valid  = c_q.valid;
    assign err_sticky = c_q.err;
endmodule

// File: rtl/lsf_checker.sv
module lsf_checker #(
    parameter int LANES = 3,
    parameter int DEPTH = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             rd_en,
    input logic             lock,
    input logic             disc,
    input logic             out_valid,
    input logic             err_sticky,
    input logic             init,
    input logic             fault,
    input logic [LANES-1:0] out_bit
);
    localparam int LIM = DEPTH / 2 + 2;

    int reads_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                     reads_q <= 0;
        else if (init)                  reads_q <= 0;
        else if (rd_en && reads_q <= LIM) reads_q <= reads_q + 1;
    end

    // R2
    hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(out_bit));

    // R3
    disc_clears_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        disc |=> !out_valid);

    // R3
    settle_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (reads_q > LIM));

    // R4
    valid_needs_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(lock));

    // R7
    fault_drops_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fault |=> !out_valid);

    // R8
    fault_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fault |=> err_sticky);

    // R9
    err_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(err_sticky) |-> err_sticky);
endmodule

bind lane_skew_fifo lsf_checker #(.LANES(LANES), .DEPTH(DEPTH)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .rd_en      (rd_en),
    .lock       (lock),
    .disc       (disc),
    .out_valid  (out_valid),
    .err_sticky (err_sticky),
    .init       (init_w),
    .fault      (fault_w),
    .out_bit    (out_bit)
);

// File: tb/sim_lane_skew_fifo.sv
module sim_lane_skew_fifo;
    logic       clk = 1'b0;
    logic       rst_n;
    logic [2:0] wr_stb;
    logic [2:0] wr_bit;
    logic       rd_en;
    logic       lock;
    logic       disc;
    logic [2:0] out_bit;
    logic       out_valid;
    logic       err_sticky;

    always #5 clk = ~clk;

    lane_skew_fifo u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_stb     (wr_stb),
        .wr_bit     (wr_bit),
        .rd_en      (rd_en),
        .lock       (lock),
        .disc       (disc),
        .out_bit    (out_bit),
        .out_valid  (out_valid),
        .err_sticky (err_sticky)
    );

    int n_chk = 0;
    int n_bad = 0;
    int cyc   = 0;
    int bitpos = 0;
    int skew [3];
    int lag  [3];
    logic [15:0] tb_rng = 16'h1D2B;
    logic [9:0]  sym    = '0;
    bit src_h [0:4095];
    bit out_h [0:2][0:4095];
    bit val_h [0:4095];
    logic [2:0] exp_q [$];

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: got %0d expected %0d (slot %0d)", req, act, exp, cyc);
        end
    endtask

    // Driver: one bit slot per clock; outputs sampled at the falling edge.
    task automatic tick();
        if (bitpos == 0) begin
            tb_rng = {tb_rng[14:0], tb_rng[15] ^ tb_rng[14] ^ tb_rng[12] ^ tb_rng[3]};
            sym    = tb_rng[9:0];
        end
        src_h[cyc] = sym[bitpos];
        bitpos = (bitpos == 9) ? 0 : bitpos + 1;
        for (int k = 0; k < 3; k++)
            wr_bit[k] = (cyc >= skew[k]) ? src_h[cyc - skew[k]] : 1'b0;
        @(negedge clk);
        for (int k = 0; k < 3; k++) out_h[k][cyc] = out_bit[k];
        val_h[cyc] = out_valid;
        cyc++;
    endtask

    function automatic int find_lag(input int k, input int a, input int b);
        for (int t = 0; t <= 16; t++) begin
            bit ok = 1'b1;
            for (int m = a; m <= b; m++)
                if (out_h[k][m] != src_h[m - t]) ok = 1'b0;
            if (ok) return t;
        end
        return -1;
    endfunction

    task automatic round(input int s0, input int s1, input int s2);
        int d;
        int lo;
        int hi;
        int slo;
        int shi;
        skew[0] = s0; skew[1] = s1; skew[2] = s2;
        d = cyc;
        disc = 1'b1;
        tick();
        disc = 1'b0;
        repeat (7) tick();
        chk(val_h[d] == 1'b0,     "R3 valid low after disc", int'(val_h[d]), 0);
        chk(val_h[d+6] == 1'b0,   "R3 valid low before settle", int'(val_h[d+6]), 0);
        chk(val_h[d+7] == 1'b1,   "R3 valid on 7th edge", int'(val_h[d+7]), 1);
        repeat (40) tick();
        lo = 99; hi = -99; slo = 99; shi = -99;
        for (int k = 0; k < 3; k++) begin
            lag[k] = find_lag(k, d + 10, d + 45);
            chk(lag[k] >= 0, "R6 lane stream found", lag[k], 0);
            chk(lag[k] - skew[k] >= 4 && lag[k] - skew[k] <= 6,
                "R5 lane lead in 4..6", lag[k] - skew[k], 5);
            if (lag[k] < lo) lo = lag[k];
            if (lag[k] > hi) hi = lag[k];
            if (skew[k] < slo) slo = skew[k];
            if (skew[k] > shi) shi = skew[k];
        end
        chk(hi - lo <= shi - slo + 2, "R5 output skew bound", hi - lo, shi - slo + 2);
        // Scoreboard: expected word pushed per slot, popped and compared after it.
        for (int i = 0; i < 80; i++) begin
            logic [2:0] e;
            logic [2:0] got;
            for (int k = 0; k < 3; k++) e[k] = src_h[cyc - lag[k]];
            exp_q.push_back(e);
            tick();
            e = exp_q.pop_front();
            for (int k = 0; k < 3; k++) got[k] = out_h[k][cyc-1];
            chk(val_h[cyc-1] == 1'b1 && got == e, "R6 constant lag data",
                int'(got), int'(e));
        end
    endtask

    initial begin
        rst_n = 1'b0; wr_stb = 3'b111; wr_bit = '0; rd_en = 1'b1;
        lock = 1'b1; disc = 1'b0;
        skew[0] = 0; skew[1] = 0; skew[2] = 0;
        repeat (3) tick();
        chk(out_valid == 1'b0,  "R1 reset valid", int'(out_valid), 0);
        chk(err_sticky == 1'b0, "R1 reset err", int'(err_sticky), 0);
        chk(out_bit == 3'b000,  "R1 reset data", int'(out_bit), 0);
        rst_n = 1'b1;
        tick();
        chk(out_valid == 1'b0 && out_bit == 3'b000, "R1 after reset", int'(out_valid), 0);
        repeat (10) tick();

        round(0, 0, 0);
        round(2, 0, 0);
        begin : lock_test
            int d;
            d = cyc;
            lock = 1'b0;
            repeat (3) tick();
            lock = 1'b1;
            repeat (2) tick();
            chk(val_h[d] == 1'b0,   "R4 valid drops with lock", int'(val_h[d]), 0);
            chk(val_h[d+2] == 1'b0, "R4 valid held low", int'(val_h[d+2]), 0);
            chk(val_h[d+3] == 1'b1, "R4 valid on lock return", int'(val_h[d+3]), 1);
        end
        round(0, 1, 3);
        round(1, 1, 0);

        begin : underflow_test
            int s;
            int e;
            s = cyc;
            e = -1;
            wr_stb = 3'b110;
            for (int i = 0; i < 12 && e < 0; i++) begin
                tick();
                if (val_h[cyc-1] == 1'b0) e = cyc - 1;
            end
            wr_stb = 3'b111;
            chk(e - s >= 4 && e - s <= 6, "R7 underflow after lead", e - s, 5);
            chk(err_sticky == 1'b1, "R7 err set", int'(err_sticky), 1);
            repeat (10) tick();
            chk(e >= 0 && val_h[e+7] == 1'b0, "R7 valid low during resettle", int'(val_h[e+7]), 0);
            chk(e >= 0 && val_h[e+8] == 1'b1, "R7 valid back", int'(val_h[e+8]), 1);
        end

        begin : overflow_test
            int s;
            int e;
            bit held;
            s = cyc;
            e = -1;
            rd_en = 1'b0;
            for (int i = 0; i < 12 && e < 0; i++) begin
                tick();
                if (val_h[cyc-1] == 1'b0) e = cyc - 1;
            end
            rd_en = 1'b1;
            held = 1'b1;
            for (int m = s; m <= e; m++)
                for (int k = 0; k < 3; k++)
                    if (out_h[k][m] != out_h[k][s-1]) held = 1'b0;
            chk(e >= s && held, "R2 outputs hold while reads stall", int'(held), 1);
            chk(e - s >= 2 && e - s <= 4, "R8 overflow after fill", e - s, 3);
            repeat (10) tick();
            chk(e >= 0 && val_h[e+7] == 1'b0, "R8 valid low during resettle", int'(val_h[e+7]), 0);
            chk(e >= 0 && val_h[e+8] == 1'b1, "R8 valid back", int'(val_h[e+8]), 1);
        end

        round(0, 2, 1);
        chk(err_sticky == 1'b1, "R9 err held through disc", int'(err_sticky), 1);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: got %0d expected %0d", 0, 1);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule